// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block runs single-byte register reads and writes to a peripheral over a three-wire serial link: an active-low select, a serial clock that idles low, and one bidirectional data line. The line is presented as a separate output, output enable and input. A pad or the board combines them. A host starts an access by pulsing a command strobe with a direction flag, a 13-bit register address, a write byte and a half-period length. The block then runs one 24-clock frame and signals completion with a one-cycle done strobe. For reads, the returned byte appears at the same time as the strobe.

Each frame starts with a 16-bit instruction word that the master drives. An 8-bit data phase follows. On a write the master keeps driving the line for the data byte. On a read it turns its driver off once the instruction has been sent, and the peripheral shifts the byte out after falling clock edges. The peripheral lets go of the line right after the final rising edge, which falls halfway through the last bit, and an undriven line drifts low. For this reason the master samples every read bit in the system clock cycle that raises the serial clock, before the rise takes effect. The last bit is therefore captured while it is still driven.

Top module: `spi3w_reg_master`

## Requirements
- R1: After reset and whenever no access is running, `spi_cs_n` is 1, `spi_sclk` is 0, `sdio_oe` is 0, `busy` is 0 and `done` is 0; `rd_data` resets to 0.
- R2: A command is taken only in a cycle where `busy` is 0 and `cmd_valid` is 1. A `cmd_valid` pulse while `busy` is 1 has no effect on the frame in progress and does not start a later frame.
- R3: Each half of every serial clock period lasts `half_period` system cycles (a value of 0 acts as 1). The frame holds `spi_cs_n` low for exactly 24 clock periods, each starting low then going high.
- R4: The first 16 bits sent, MSB first, are the instruction: bit 15 is 1 for read and 0 for write, bits 14:13 are 00, bits 12:0 are the address. Bit 15 is on `sdio_o` from the cycle select falls, and each later bit changes with a falling serial clock edge.
- R5: On a write, the 8 data bits follow MSB first on the next 8 clock periods, and `sdio_oe` stays 1 until select rises.
- R6: On a read, `sdio_oe` goes to 0 with the 16th falling clock edge and stays 0 until the frame ends.
- R7: Each of the 8 read bits is sampled from `sdio_i` in the system cycle whose edge raises `spi_sclk`, MSB first. Bit 0 is therefore captured even if the line is released right after the 24th rising edge.
- R8: One half-period after the 24th falling edge, `spi_cs_n` rises. In that same cycle `done` is 1 for one cycle and `busy` returns to 0. A command presented then is taken at the next edge.
- R9: `rd_data` changes only when a read finishes, taking the byte read; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 13 | Register address |
| cmd_wdata | input | 8 | Byte to write |
| half_period | input | 8 | System cycles per serial clock half-period |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access strobe |
| rd_data | output | 8 | Last byte read |
| spi_cs_n | output | 1 | Active-low select |
| spi_sclk | output | 1 | Serial clock, idles low |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input value |

## Verification
Two functions can fall in the same cycle. The first is the end of one access: the done strobe and the fall of busy. The second is the taking of a new command. The bench holds `cmd_valid` high across a done cycle, and the reference model expects the next frame to start exactly one edge later with no dead cycle. It also injects a command in the middle of a read and expects no effect. A bench peripheral releases the data line right after the 24th rise and lets it fall to 0 at once, so a bit sampled too late is read wrongly. Read bytes with bit 0 set expose this.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_state_t;

  localparam int WLEN_BITS = 2;

  // last counter value of a half-period; a length of zero behaves as one
  function automatic logic [15:0] half_last(input logic [15:0] len);
    return (len == 16'd0) ? 16'd0 : len - 16'd1;
  endfunction

endpackage

// File: rtl/spi3w_half_timer.sv
module spi3w_half_timer #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] half_len,
  output logic            tick
);
  import spi3w_pkg::*;

  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] last_v;
  logic [15:0]     last_w;

  assign last_w = half_last(16'(half_len));
  assign last_v = last_w[HP_W-1:0];
  assign tick   = run && (cnt_q == last_v);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));  // R3

endmodule

// File: rtl/spi3w_frame_seq.sv
module spi3w_frame_seq #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int HP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [HP_W-1:0]   half_period,
  input  logic              tick,
  output logic [HP_W-1:0]   hp_q,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sample_en,
  output logic              commit_rd,
  output logic              done
);
  import spi3w_pkg::*;

  localparam int INSTR_W = 1 + WLEN_BITS + ADDR_W;
  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_INST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] FIRST_DAT = CNT_W'(INSTR_W);

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic rd, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [INSTR_W-1:0] ins;
    ins = {rd, {WLEN_BITS{1'b0}}, a};
    return {ins, rd ? {DATA_W{1'b0}} : d};
  endfunction

  seq_state_t         state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic               rd_q;

  // named internal events
  logic accept_ev, rise_ev, fall_ev, end_ev, in_data;
  assign accept_ev = (state_q == ST_IDLE) && cmd_valid;
  assign rise_ev   = (state_q == ST_LOW)  && tick;
  assign fall_ev   = (state_q == ST_HIGH) && tick;
  assign end_ev    = (state_q == ST_TAIL) && tick;
  assign in_data   = (bit_cnt_q >= FIRST_DAT);

  assign busy      = (state_q != ST_IDLE);
  assign sdio_o    = frame_q[FRAME_W-1];
  assign sample_en = rise_ev && rd_q && in_data;
  assign commit_rd = end_ev && rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      bit_cnt_q <= '0;
      rd_q      <= 1'b0;
      hp_q      <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      sdio_oe   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_ev) begin
          frame_q   <= build_frame(cmd_read, cmd_addr, cmd_wdata);
          rd_q      <= cmd_read;
          hp_q      <= half_period;
          bit_cnt_q <= '0;
          cs_n      <= 1'b0;
          sdio_oe   <= 1'b1;
          state_q   <= ST_LOW;
        end
        ST_LOW: if (rise_ev) begin
          sclk    <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (fall_ev) begin
          sclk <= 1'b0;
          if (bit_cnt_q == LAST_BIT) begin
            state_q <= ST_TAIL;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            frame_q   <= frame_q << 1;
            if (rd_q && bit_cnt_q == LAST_INST) sdio_oe <= 1'b0;
            state_q   <= ST_LOW;
          end
        end
        ST_TAIL: if (end_ev) begin
          cs_n    <= 1'b1;
          sdio_oe <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= LAST_BIT);  // R3
  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(hp_q) && $stable(rd_q)));  // R2
  AST_DRIVE_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !in_data) |-> sdio_oe);  // R4
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !sdio_oe);  // R6
  AST_SAMPLE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (!sclk && !cs_n));  // R7

endmodule

// File: rtl/spi3w_rx_capture.sv
module spi3w_rx_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              sdio_i,
  input  logic              commit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shift_q;
  logic [SC_W-1:0]   taken_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      taken_q <= '0;
      rd_data <= '0;
    end else begin
      if (sample_en) begin
        shift_q <= {shift_q[DATA_W-2:0], sdio_i};
        taken_q <= taken_q + 1'b1;
      end
      if (commit) begin
        rd_data <= shift_q;
        taken_q <= '0;
      end
    end
  end

  AST_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (taken_q == SC_W'(DATA_W)));  // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rd_data));  // R9

endmodule

// File: rtl/spi3w_reg_master.sv
module spi3w_reg_master #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int HP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [HP_W-1:0]   half_period,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic              sdio_i
);

  logic [HP_W-1:0] hp_q;
  logic            tick, sample_en, commit_rd;

  spi3w_half_timer #(.HP_W(HP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_len (hp_q),
    .tick     (tick)
  );

  spi3w_frame_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HP_W(HP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_read    (cmd_read),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .half_period (half_period),
    .tick        (tick),
    .hp_q        (hp_q),
    .busy        (busy),
    .cs_n        (spi_cs_n),
    .sclk        (spi_sclk),
    .sdio_o      (sdio_o),
    .sdio_oe     (sdio_oe),
    .sample_en   (sample_en),
    .commit_rd   (commit_rd),
    .done        (done)
  );

  spi3w_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .sdio_i    (sdio_i),
    .commit    (commit_rd),
    .rd_data   (rd_data)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sclk && !sdio_oe));  // R1
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && spi_cs_n));  // R8

endmodule

// File: tb/spi3w_reg_master_tb.sv
module spi3w_reg_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [7:0]  half_period = 8'd1;
  logic        busy, done, spi_cs_n, spi_sclk, sdio_o, sdio_oe, sdio_i;
  logic [7:0]  rd_data;

  always #5 clk = ~clk;

  spi3w_reg_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .half_period(half_period),
    .busy(busy), .done(done), .rd_data(rd_data), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- peripheral model: releases the line right after rise 24
  logic [7:0]  mem [8];
  logic        slv_drv = 1'b0, slv_bit = 1'b0;
  int          r_cnt = 0, f_cnt = 0;
  logic [15:0] s_instr = '0;
  logic [7:0]  s_wbyte = '0;

  assign sdio_i = sdio_oe ? sdio_o : (slv_drv ? slv_bit : 1'b0);

  always @(posedge spi_cs_n) begin
    r_cnt = 0; f_cnt = 0; slv_drv = 1'b0;
  end
  always @(posedge spi_sclk) begin
    if (spi_cs_n == 1'b0) begin
      r_cnt++;
      if (r_cnt <= 16) s_instr = {s_instr[14:0], sdio_i};
      else if (!s_instr[15]) s_wbyte = {s_wbyte[6:0], sdio_i};
      if (r_cnt == 24) begin
        slv_drv = 1'b0;
        if (!s_instr[15]) mem[s_instr[2:0]] = s_wbyte;
      end
    end
  end
  always @(negedge spi_sclk) begin
    if (spi_cs_n == 1'b0) begin
      f_cnt++;
      if (s_instr[15] && f_cnt >= 16 && f_cnt <= 23) begin
        slv_drv = 1'b1;
        slv_bit = mem[s_instr[2:0]][23 - f_cnt];
      end
    end
  end

  // ---------------- behavioural reference model
  logic [7:0]  shadow [8];
  bit          m_act = 0, m_done = 0, m_rd = 0;
  int          m_k = 0, m_hp = 1;
  logic [23:0] m_frame = '0;
  logic [7:0]  m_rdata = '0;
  bit          inject_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_rdata = '0;
    end else begin
      m_done = 0;
      if (m_act) begin
        m_k++;
        if (m_k == 49 * m_hp) begin
          m_act = 0; m_done = 1;
          if (m_rd) m_rdata = shadow[m_frame[10:8]];
        end
      end else if (cmd_valid) begin
        m_act = 1; m_k = 0; m_rd = cmd_read;
        m_hp = (half_period == 0) ? 1 : int'(half_period);
        m_frame = {cmd_read, 2'b00, cmd_addr, cmd_read ? 8'h00 : cmd_wdata};
        if (!cmd_read) shadow[cmd_addr[2:0]] = cmd_wdata;
      end
    end
  end

  // ---------------- per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int h, b;
      bit e_sclk, e_oe;
      h = m_k / m_hp;
      e_sclk = m_act && h < 48 && (h % 2 == 1);
      e_oe   = m_act && (!m_rd || h < 32);
      if (!m_act) begin
        chk(spi_cs_n && !spi_sclk && !sdio_oe && !busy, "R1", "idle pins",
            {spi_cs_n, spi_sclk, sdio_oe, busy}, 4'b1000);
      end else begin
        chk(spi_sclk == e_sclk, "R3", "sclk", spi_sclk, e_sclk);
        chk(!spi_cs_n && busy, "R3", "select/busy in frame", {spi_cs_n, busy}, 2'b01);
        chk(sdio_oe == e_oe, m_rd ? "R6" : "R5", "oe", sdio_oe, e_oe);
        if (e_oe) begin
          b = (h < 48) ? h / 2 : 23;
          chk(sdio_o == m_frame[23 - b], (b < 16) ? "R4" : "R5", "sdio_o bit",
              sdio_o, m_frame[23 - b]);
        end
      end
      chk(done == m_done, "R8", "done", done, m_done);
      chk(rd_data == m_rdata, m_done ? "R7" : "R9", "rd_data", rd_data, m_rdata);
      if (m_done)
        chk(s_instr == m_frame[23:8], inject_seen ? "R2" : "R4",
            "instruction seen by peripheral", s_instr, m_frame[23:8]);
      if (sdio_oe && slv_drv) chk(0, "R6", "line contention", 1, 0);
    end
  end

  // ---------------- watchdog
  int cyc = 0;
  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL R3 watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus
  task automatic issue(input bit rd, input logic [12:0] a, input logic [7:0] d,
                       input logic [7:0] hp);
    @(negedge clk);
    cmd_read = rd; cmd_addr = a; cmd_wdata = d; half_period = hp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    mem[0] = 8'hC3; mem[1] = 8'h8F; mem[2] = 8'h5A; mem[3] = 8'h01;
    mem[4] = 8'h7E; mem[5] = 8'hF0; mem[6] = 8'h00; mem[7] = 8'hFF;
    for (int i = 0; i < 8; i++) shadow[i] = mem[i];
    repeat (4) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && !sdio_oe && !busy && !done && rd_data == 8'h00,
        "R1", "reset state", {spi_cs_n, spi_sclk, sdio_oe, busy}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    issue(1, 13'h0001, 8'h00, 8'd2);  wait_done();   // R7 bit 0 set
    issue(0, 13'h1A02, 8'h35, 8'd1);  wait_done();   // R5 write, R9 hold
    issue(1, 13'h0002, 8'h00, 8'd0);  wait_done();   // R3 zero half-period
    issue(1, 13'h0007, 8'h00, 8'd3);                 // R2 inject mid-frame
    repeat (40) @(negedge clk);
    inject_seen = 1;
    cmd_read = 0; cmd_addr = 13'h0000; cmd_wdata = 8'h00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    chk(!busy, "R2", "no frame started by ignored command", busy, 0);
    inject_seen = 0;
    issue(1, 13'h0000, 8'h00, 8'd1);  wait_done();   // R2 address 0 untouched
    issue(0, 13'h0003, 8'hA7, 8'd2);  wait_done();   // R9 write keeps rd_data

    // R8 back-to-back: command held across the done cycle
    @(negedge clk);
    cmd_read = 1; cmd_addr = 13'h0003; half_period = 8'd1; cmd_valid = 1'b1;
    wait_done();
    @(negedge clk);
    chk(busy && !spi_cs_n, "R8", "next frame starts right after done",
        {busy, spi_cs_n}, 2'b10);
    cmd_addr = 13'h0005;
    wait_done();
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n, "R8", "idle after held command dropped",
        {busy, spi_cs_n}, 2'b01);
    finish_run();
  end

endmodule